// File: doc/BRIEF.md
# Single-Correct, Double-Detect Block Decoder with Sample Concealment

This block decodes 63-bit codewords, each holding 56 data bits and 7 check bits. It corrects a single flipped bit anywhere in the word and flags a word with two flipped bits as uncorrectable. The code is generated by g(x) = (x^6+x+1)(x+1). Codeword bit i carries the coefficient of x^i. Data bit j sits at codeword bit j+7, and bits 6:0 hold the remainder of d(x)·x^7 divided by g(x). The decoder splits the 7-bit syndrome into a 6-bit remainder modulo the primitive factor and an overall parity bit. A non-zero remainder with odd parity points at exactly one bit position. Even parity with a non-zero remainder means a double error.

The low `SAMPLE_W` bits of the data, 16 by default and read as two's complement, form an audio sample. When a word carries a double error, its sample is replaced according to `conceal_mode`:

- With `conceal_mode` = 0, the last good sample is held.
- With `conceal_mode` = 1, the sample becomes the mean of the last good sample and the sample of the following word. If the following word is also a double error, the last good sample is held instead.

Because of this look-ahead, word k leaves the block only when word k+1 arrives. The last word accepted stays buffered until another word follows it.

Top module: `bch_conceal_dec`

## Requirements
- R1: A codeword with no bit errors is delivered with its 56 data bits unchanged and with out_single, out_double and out_err all low.
- R2: A codeword with exactly one flipped bit, in any of the 63 positions (data or check), is delivered with the original data restored, out_single high and out_double low.
- R3: A codeword with exactly two flipped bits is delivered with out_double high and out_single low. Its data bits above the sample field equal the received, uncorrected bits.
- R4: On every output word, out_err equals the OR of out_single and out_double.
- R5: In hold mode (conceal_mode = 0, sampled on the edge that emits the word), a double-error word's sample equals the last good sample. The last good sample is the sample of the most recent word delivered without a double error, single-corrected words included. After reset it is zero.
- R6: In interpolate mode (conceal_mode = 1), a double-error word followed by a word without a double error gets the sample floor((last_good + next) / 2), computed with signed arithmetic.
- R7: In interpolate mode, a double-error word followed by another double-error word holds the last good sample.
- R8: Word k is delivered, with out_valid high for one cycle, on the third rising edge counted from the edge that accepts word k+1 (the accepting edge is the first). Every accepted word except the most recent is delivered exactly once, in order.
- R9: While reset is asserted, out_valid, out_single, out_double, out_err and in_ready are low. out_err is low in every cycle in which out_valid is low.
- R10: After reset is released, in_ready goes high within three clock edges and stays high, so a new word can be accepted on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A codeword is offered on in_code |
| in_ready | output | 1 | The block accepts a word on this edge |
| in_code | input | 63 | Received codeword, bit i = coefficient of x^i |
| conceal_mode | input | 1 | 0 = hold last good sample, 1 = interpolate |
| out_valid | output | 1 | One-cycle strobe for a delivered word |
| out_data | output | 56 | Corrected data; bits 15:0 hold the sample, concealed when needed |
| out_single | output | 1 | A single error was corrected in this word |
| out_double | output | 1 | A double error was detected in this word |
| out_err | output | 1 | Any error was detected in this word |

## Verification
The checker watches several properties on every cycle:

- the two status flags are never high together;
- out_err agrees with them and stays quiet between output words;
- each delivery lies exactly three edges after an accepted word, and in_ready never drops once it has risen;
- in hold mode, a concealed sample matches a last good sample that the checker tracks from the output port alone.

Some behaviours can only be shown by the bench's scenarios. These are the correctness of the corrected data at each of the 63 error positions and the detection of every one of the 1953 possible double errors. They also include the floor-rounded signed mean and the fallback to hold when two double errors come in a row. The bench also covers back-to-back acceptance with the word order kept.

// File: rtl/bchc_pkg.sv
package bchc_pkg;

  typedef enum logic {
    CONCEAL_HOLD   = 1'b0,
    CONCEAL_INTERP = 1'b1
  } conceal_e;

  // x^e reduced modulo the primitive polynomial prim of degree m
  function automatic logic [15:0] gf_pow(input int m, input logic [15:0] prim, input int e);
    logic [15:0] r;
    r = 16'd1;
    for (int t = 0; t < e; t++) begin
      r = {r[14:0], 1'b0};
      if (r[m]) r = r ^ prim;
    end
    return r;
  endfunction

endpackage

// File: rtl/bchc_syndrome.sv
module bchc_syndrome #(
  parameter int          M    = 6,
  parameter logic [15:0] PRIM = 16'h0043,
  localparam int         N    = (1 << M) - 1
) (
  input  logic [N-1:0] cw,
  output logic [M-1:0] syn,
  output logic         par
);
  import bchc_pkg::*;

  logic [M-1:0] term [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_term
    localparam logic [15:0] APOW = gf_pow(M, PRIM, gi);
    assign term[gi] = cw[gi] ? APOW[M-1:0] : '0;
  end

  always_comb begin
    syn = '0;
    for (int i = 0; i < N; i++) syn = syn ^ term[i];
  end

  assign par = ^cw;
endmodule

// File: rtl/bchc_locator.sv
module bchc_locator #(
  parameter int          M    = 6,
  parameter logic [15:0] PRIM = 16'h0043,
  localparam int         N    = (1 << M) - 1,
  localparam int         R    = M + 1,
  localparam int         K    = N - R
) (
  input  logic [N-1:0] cw,
  input  logic [M-1:0] syn,
  input  logic         par,
  output logic [K-1:0] data,
  output logic         single,
  output logic         double
);
  import bchc_pkg::*;

  logic [N-1:0] hit;

  for (genvar gi = 0; gi < N; gi++) begin : g_hit
    localparam logic [15:0] APOW = gf_pow(M, PRIM, gi);
    assign hit[gi] = par && (syn == APOW[M-1:0]);
  end

  assign data   = cw[N-1:R] ^ hit[N-1:R];
  assign single = |hit;
  assign double = (par || (syn != '0)) && !(|hit);
endmodule

// File: rtl/bchc_conceal.sv
module bchc_conceal #(
  parameter int K  = 56,
  parameter int SW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_vld,
  input  logic [K-1:0] d_data,
  input  logic         d_sgl,
  input  logic         d_dbl,
  input  logic         mode,
  output logic         o_vld,
  output logic [K-1:0] o_data,
  output logic         o_sgl,
  output logic         o_dbl,
  output logic         o_err
);
  import bchc_pkg::*;

  logic          p_vld, p_sgl, p_dbl;
  logic [K-1:0]  p_data;
  logic [SW-1:0] last_q;

  logic          emit;
  logic [SW-1:0] cur_s, nxt_s, conc_s, last_n;
  logic [SW:0]   sum;
  logic [K-1:0]  o_data_n;

  always_comb begin
    emit   = d_vld && p_vld;
    cur_s  = p_data[SW-1:0];
    nxt_s  = d_data[SW-1:0];
    sum    = {last_q[SW-1], last_q} + {nxt_s[SW-1], nxt_s};
    if (!p_dbl)
      conc_s = cur_s;
    else if ((conceal_e'(mode) == CONCEAL_INTERP) && !d_dbl)
      conc_s = SW'(sum >> 1);
    else
      conc_s = last_q;
    o_data_n = {p_data[K-1:SW], conc_s};
    last_n   = (emit && !p_dbl) ? cur_s : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_sgl  <= 1'b0;
      p_dbl  <= 1'b0;
      p_data <= '0;
      last_q <= '0;
      o_vld  <= 1'b0;
      o_sgl  <= 1'b0;
      o_dbl  <= 1'b0;
      o_err  <= 1'b0;
      o_data <= '0;
    end else begin
      o_vld  <= emit;
      o_sgl  <= emit && p_sgl;
      o_dbl  <= emit && p_dbl;
      o_err  <= emit && (p_sgl || p_dbl);
      last_q <= last_n;
      if (emit) o_data <= o_data_n;
      if (d_vld) begin
        p_vld  <= 1'b1;
        p_sgl  <= d_sgl;
        p_dbl  <= d_dbl;
        p_data <= d_data;
      end
    end
  end
endmodule

// File: rtl/bch_conceal_dec.sv
module bch_conceal_dec #(
  parameter int          M        = 6,
  parameter logic [15:0] PRIM     = 16'h0043,
  parameter int          SAMPLE_W = 16,
  localparam int         N        = (1 << M) - 1,
  localparam int         R        = M + 1,
  localparam int         K        = N - R
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_code,
  input  logic         conceal_mode,
  output logic         out_valid,
  output logic [K-1:0] out_data,
  output logic         out_single,
  output logic         out_double,
  output logic         out_err
);

  // reset synchroniser: asserts at once, releases on a clock edge
  logic rst_q1, rst_q2, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_s_n = rst_q2;

  logic rdy_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) rdy_q <= 1'b0;
    else          rdy_q <= 1'b1;
  end
  assign in_ready = rdy_q;

  logic accept;
  assign accept = in_valid && rdy_q;

  // stage 1: syndrome
  logic [M-1:0] syn_c;
  logic         par_c;
  bchc_syndrome #(.M(M), .PRIM(PRIM)) u_syn (
    .cw (in_code),
    .syn(syn_c),
    .par(par_c)
  );

  logic         s1_vld, s1_par;
  logic [N-1:0] s1_cw;
  logic [M-1:0] s1_syn;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      s1_vld <= 1'b0;
      s1_par <= 1'b0;
      s1_cw  <= '0;
      s1_syn <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_cw  <= in_code;
        s1_syn <= syn_c;
        s1_par <= par_c;
      end
    end
  end

  // stage 2: locate and correct
  logic [K-1:0] fix_c;
  logic         sgl_c, dbl_c;
  bchc_locator #(.M(M), .PRIM(PRIM)) u_loc (
    .cw    (s1_cw),
    .syn   (s1_syn),
    .par   (s1_par),
    .data  (fix_c),
    .single(sgl_c),
    .double(dbl_c)
  );

  logic         d_vld, d_sgl, d_dbl;
  logic [K-1:0] d_data;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      d_vld  <= 1'b0;
      d_sgl  <= 1'b0;
      d_dbl  <= 1'b0;
      d_data <= '0;
    end else begin
      d_vld <= s1_vld;
      if (s1_vld) begin
        d_data <= fix_c;
        d_sgl  <= sgl_c;
        d_dbl  <= dbl_c;
      end
    end
  end

  // stage 3: one-word look-ahead and concealment
  bchc_conceal #(.K(K), .SW(SAMPLE_W)) u_conc (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_vld (d_vld),
    .d_data(d_data),
    .d_sgl (d_sgl),
    .d_dbl (d_dbl),
    .mode  (conceal_mode),
    .o_vld (out_valid),
    .o_data(out_data),
    .o_sgl (out_single),
    .o_dbl (out_double),
    .o_err (out_err)
  );
endmodule

// File: rtl/bchc_checker.sv
module bchc_checker #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          conceal_mode,
  input logic          out_valid,
  input logic [SW-1:0] out_sample,
  input logic          out_single,
  input logic          out_double,
  input logic          out_err
);
  logic [SW-1:0] good_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= '0;
    else if (out_valid && !out_double) good_q <= out_sample;
  end

  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_single && out_double));

  // R4
  err_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err == (out_single || out_double)));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_err);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 3));

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready);

  // R5
  hold_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_double && !$past(conceal_mode)) |-> (out_sample == good_q));
endmodule

bind bch_conceal_dec bchc_checker #(.SW(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .conceal_mode(conceal_mode),
  .out_valid   (out_valid),
  .out_sample  (out_data[SAMPLE_W-1:0]),
  .out_single  (out_single),
  .out_double  (out_double),
  .out_err     (out_err)
);

// File: tb/tb_bch_conceal_dec.sv
module tb_bch_conceal_dec;
  localparam int N  = 63;
  localparam int K  = 56;
  localparam int SW = 16;
  localparam int MAXW = 8192;

  logic clk, rst_n, in_valid, in_ready, conceal_mode;
  logic [N-1:0] in_code;
  logic out_valid, out_single, out_double, out_err;
  logic [K-1:0] out_data;

  bch_conceal_dec dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .conceal_mode(conceal_mode), .out_valid(out_valid),
    .out_data(out_data), .out_single(out_single), .out_double(out_double),
    .out_err(out_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [K-1:0] tdat [MAXW];
  logic [K-1:0] rdat [MAXW];
  int           kind [MAXW];
  logic         emode[MAXW];
  int           accc [MAXW];
  int nw = 0;
  int ne = 0;
  logic [SW-1:0] lastg = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] encode(input logic [K-1:0] d);
    logic [N-1:0] t;
    t = {d, 7'b0};
    for (int i = N - 1; i >= 7; i--)
      if (t[i]) t[i -: 8] = t[i -: 8] ^ 8'hC5;
    return {d, t[6:0]};
  endfunction

  // call at a negedge; returns at a negedge
  task automatic send(input logic [K-1:0] d, input int k, input int e1, input int e2, input int gap);
    logic [N-1:0] cw;
    cw = encode(d);
    if (k >= 1) cw[e1] = ~cw[e1];
    if (k == 2) cw[e2] = ~cw[e2];
    chk(in_ready == 1'b1, "R10 ready", 64'(in_ready), 64'd1);
    tdat[nw]  = d;
    rdat[nw]  = cw[N-1:7];
    kind[nw]  = k;
    emode[nw] = conceal_mode;
    accc[nw]  = cyc + 1;
    nw++;
    in_valid = 1'b1;
    in_code  = cw;
    @(negedge clk);
    if (gap > 0) begin
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  function automatic logic [K-1:0] rnd56();
    return {$urandom(), $urandom()};
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (out_valid && !done) begin
      int k;
      logic [SW-1:0] es;
      logic [SW-1:0] ns;
      int sm;
      k = ne;
      ne++;
      chk(cyc == accc[k+1] + 2, "R8 latency", 64'(cyc), 64'(accc[k+1] + 2));
      chk(out_err == (out_single | out_double), "R4 err", 64'(out_err), 64'(out_single | out_double));
      if (kind[k] == 0) begin
        chk(out_data == tdat[k] && !out_err, "R1 clean", {7'b0, out_err, out_data}, {8'b0, tdat[k]});
        lastg = tdat[k][SW-1:0];
      end else if (kind[k] == 1) begin
        chk(out_data == tdat[k] && out_single && !out_double, "R2 single",
            {6'b0, out_single, out_double, out_data}, {6'b0, 2'b10, tdat[k]});
        lastg = tdat[k][SW-1:0];
      end else begin
        chk(out_double && !out_single && out_data[K-1:SW] == rdat[k][K-1:SW], "R3 double",
            {6'b0, out_single, out_double, out_data}, {6'b0, 2'b01, rdat[k]});
        ns = tdat[k+1][SW-1:0];
        if (emode[k+1] == 1'b0) begin
          es = lastg;
          chk(out_data[SW-1:0] == es, "R5 hold", 64'(out_data[SW-1:0]), 64'(es));
        end else if (kind[k+1] != 2) begin
          sm = ($signed(lastg) + $signed(ns)) >>> 1;
          es = sm[SW-1:0];
          chk(out_data[SW-1:0] == es, "R6 interp", 64'(out_data[SW-1:0]), 64'(es));
        end else begin
          es = lastg;
          chk(out_data[SW-1:0] == es, "R7 interp fallback", 64'(out_data[SW-1:0]), 64'(es));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'(cyc), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int p;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_code = '0;
    conceal_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_err && !out_single && !out_double && !in_ready, "R9 reset",
        {59'b0, out_valid, out_err, out_single, out_double, in_ready}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R10 ready after reset", 64'(in_ready), 64'd1);
    chk(!out_valid && !out_err, "R9 idle", {62'b0, out_valid, out_err}, 64'd0);

    // first word a double in hold mode: conceals to zero (R5)
    send(rnd56(), 2, 3, 40, 4);
    for (int i = 0; i < 16; i++) send(rnd56(), 0, 0, 0, 4);
    // every single-error position, data and check bits (R2)
    for (int i = 0; i < N; i++) send(rnd56(), 1, i, 0, 4);

    // every double-error pair (R3, R5, R6, R7)
    p = 0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        conceal_mode = p[2];
        send(rnd56(), 2, i, j, 4);
        if (p % 4 != 3) begin
          if (p % 2 == 1) send(rnd56(), 1, p % N, 0, 4);
          else            send(rnd56(), 0, 0, 0, 4);
        end
        p++;
      end
    end

    // back-to-back burst in interpolate mode (R8, R10)
    conceal_mode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      int e1, e2;
      e1 = $urandom_range(0, N - 1);
      e2 = (e1 + 1 + $urandom_range(0, N - 3)) % N;
      send(rnd56(), i % 3, e1, e2, 0);
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    conceal_mode = 1'b0;
    send(rnd56(), 0, 0, 0, 6);
    chk(ne == nw - 1, "R8 count", 64'(ne), 64'(nw - 1));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule